// File: doc/BRIEF.md
# Deferred Forward-Request Recorder

While a cache line waits for its own miss for exclusive ownership to complete, forwarded requests from other nodes for the same line cannot be served yet. This block notes them as they arrive. It keeps a bit-vector of the nodes that asked to read. It also keeps one slot for the node that asked to write, together with the acknowledgement count carried in that write request.

When the local miss completes, a completion strobe with a two-bit mode starts a replay. The block then emits response descriptors on a valid/ready channel. The reader multicast always comes before the writer unicast. Data payloads are handled elsewhere; this block produces only destinations and ack counts.

A new pending miss is announced with an allocate strobe, which empties the storage. Finishing a replay also empties the storage.

Top module: `fwd_defer_recorder`

## Requirements
- R1: After reset the output valid, busy and error flags are low and nothing is recorded, so a replay in any mode emits no beat.
- R2: An allocate strobe empties the reader set and frees the writer slot. A record made in the same cycle as the allocate lands in the emptied storage.
- R3: Each reader record sets bit `rd_id_i` of the reader set. Several readers accumulate, and recording the same reader twice leaves a single bit.
- R4: A writer record stores the requestor ID and its ack count when the slot is free. When the slot is already held, the first stored values are kept.
- R5: A writer record while the slot is held raises `dup_wr_err_o`. The flag stays high until the next allocate strobe.
- R6: A reader beat has `rsp_multi_o`=1, `rsp_dest_set_o` equal to the recorded set, `rsp_acks_o`=0 and `rsp_dest_id_o`=0.
- R7: A writer beat has `rsp_multi_o`=0, the stored ID on `rsp_dest_id_o`, the stored ack count on `rsp_acks_o`, and `rsp_dest_set_o`=0.
- R8: Mode bit 0 requests the reader replay and mode bit 1 requests the writer replay. With both bits set, the reader beat is emitted first and the writer beat second, and each beat needs its own accepted handshake.
- R9: While `rsp_valid_o` is high and `rsp_ready_i` is low, valid stays high and every descriptor field holds its value.
- R10: A requested part with nothing recorded is skipped. Mode 00, or a replay with nothing to send, emits no beat.
- R11: While a replay is in progress (`busy_o`=1), record, allocate and completion strobes are ignored.
- R12: The completion of a replay, or a completion strobe that emits no beat, empties the reader set and frees the writer slot, including any part that was not replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_i | input | 1 | New pending miss; empties the storage |
| rd_rec_i | input | 1 | Record a deferred read request |
| rd_id_i | input | ID_W | Requestor ID of the read request |
| wr_rec_i | input | 1 | Record a deferred write request |
| wr_id_i | input | ID_W | Requestor ID of the write request |
| wr_acks_i | input | ACK_W | Ack count carried by the write request |
| done_i | input | 1 | Local miss completed; start the replay |
| done_mode_i | input | 2 | Bit 0: replay readers; bit 1: replay writer |
| rsp_valid_o | output | 1 | Response descriptor valid |
| rsp_ready_i | input | 1 | Consumer accepts the descriptor |
| rsp_multi_o | output | 1 | 1 = multicast to the set, 0 = unicast to the ID |
| rsp_dest_set_o | output | NODES | Multicast destination set |
| rsp_dest_id_o | output | ID_W | Unicast destination ID |
| rsp_acks_o | output | ACK_W | Ack count carried by the response |
| busy_o | output | 1 | Replay in progress |
| dup_wr_err_o | output | 1 | A second writer record arrived while the slot was held |

## Verification
The assertions assume three things about the inputs:
- A completion strobe never shares a cycle with a record strobe.
- Requestor IDs stay below NODES.
- The consumer drives `rsp_ready_i` freely.

The stimulus keeps within these assumptions as follows. Every strobe is driven for a single cycle by its own task. IDs are drawn modulo NODES. Ready is withheld for random stretches so that the hold rule is exercised.

The one deliberate overlap is an allocate together with a record. Strobes issued during a replay are accepted as stimulus, because they are meant to be ignored.

// File: rtl/dfr_pkg.sv
// Package: shared types for the deferred forward-request recorder.
// Assumes: nothing beyond standard SystemVerilog.
package dfr_pkg;
    // Bit positions inside the completion mode field.
    localparam int MODE_RD_BIT = 0;
    localparam int MODE_WR_BIT = 1;

    // Replay phase: idle, reader multicast beat, writer unicast beat.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_READERS = 2'd1,
        PH_WRITER  = 2'd2
    } replay_phase_e;
endpackage

// File: rtl/dfr_reader_set.sv
// Module: dfr_reader_set
// Holds one bit per node that asked to read while the miss is pending.
// Assumes: rec_id_i < NODES; clear_i applies before a same-cycle record.
module dfr_reader_set #(
    parameter int NODES = 8,
    localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             rec_i,
    input  logic [ID_W-1:0]  rec_id_i,
    output logic [NODES-1:0] set_o
);
    logic [NODES-1:0] set_q;
    logic [NODES-1:0] set_n;

    // Per-bit next value: keep (unless cleared), then OR in the new reader.
    for (genvar g = 0; g < NODES; g++) begin : g_bit
        always_comb begin
            set_n[g] = (set_q[g] && !clear_i) || (rec_i && (rec_id_i == ID_W'(g)));
        end
    end

    // Register the reader vector.
    always_ff @(posedge clk) begin
        if (!rst_n) set_q <= '0;
        else        set_q <= set_n;
    end

    assign set_o = set_q;

    // R3: a recorded reader appears in the set on the next cycle.
    a_r3_reader_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        rec_i |=> set_q[$past(rec_id_i)]);

    // R2: a clear with no record leaves the set empty.
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !rec_i) |=> (set_q == '0));
endmodule

// File: rtl/dfr_writer_slot.sv
// Module: dfr_writer_slot
// Holds the single deferred writer (ID and ack count) and the duplicate flag.
// Assumes: clear_i frees the slot before a same-cycle record is considered.
module dfr_writer_slot #(
    parameter int ID_W  = 3,
    parameter int ACK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             err_clr_i,
    input  logic             rec_i,
    input  logic [ID_W-1:0]  rec_id_i,
    input  logic [ACK_W-1:0] rec_acks_i,
    output logic             held_o,
    output logic [ID_W-1:0]  id_o,
    output logic [ACK_W-1:0] acks_o,
    output logic             err_o
);
    logic             held_q;
    logic [ID_W-1:0]  id_q;
    logic [ACK_W-1:0] acks_q;
    logic             err_q;
    logic             held_after_clr;
    logic             capture;
    logic             dup;

    // Decide whether a record captures into a free slot or is a duplicate.
    always_comb begin
        held_after_clr = held_q && !clear_i;
        capture        = rec_i && !held_after_clr;
        dup            = rec_i && held_after_clr;
    end

    // Slot contents: occupancy, ID and ack count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            id_q   <= '0;
            acks_q <= '0;
        end else begin
            held_q <= held_after_clr || capture;
            if (capture) begin
                id_q   <= rec_id_i;
                acks_q <= rec_acks_i;
            end
        end
    end

    // Sticky duplicate-record flag, dropped by a new allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (err_q && !err_clr_i) || dup;
    end

    assign held_o = held_q;
    assign id_o   = id_q;
    assign acks_o = acks_q;
    assign err_o  = err_q;

    // R5: a record into a held slot raises the flag.
    a_r5_dup_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_i && held_q && !clear_i) |=> err_q);

    // R4: a held slot keeps its contents unless cleared.
    a_r4_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !clear_i) |=> (held_q && $stable(id_q) && $stable(acks_q)));
endmodule

// File: rtl/dfr_replay_seq.sv
// Module: dfr_replay_seq
// Walks the replay: reader beat first, writer beat second, each on a handshake.
// Assumes: have_* inputs do not change while a replay is in progress.
module dfr_replay_seq
    import dfr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [1:0]    mode_i,
    input  logic          have_readers_i,
    input  logic          have_writer_i,
    input  logic          ready_i,
    output replay_phase_e phase_o,
    output logic          finish_o
);
    replay_phase_e ph_q, ph_n;
    logic          want_wr_q, want_wr_n;
    logic          fin;

    // Next phase and end-of-replay pulse.
    always_comb begin
        ph_n      = ph_q;
        want_wr_n = want_wr_q;
        fin       = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (done_i) begin
                    if (mode_i[MODE_RD_BIT] && have_readers_i) begin
                        ph_n      = PH_READERS;
                        want_wr_n = mode_i[MODE_WR_BIT] && have_writer_i;
                    end else if (mode_i[MODE_WR_BIT] && have_writer_i) begin
                        ph_n      = PH_WRITER;
                        want_wr_n = 1'b0;
                    end else begin
                        fin = 1'b1;
                    end
                end
            end
            PH_READERS: begin
                if (ready_i) begin
                    if (want_wr_q) begin
                        ph_n = PH_WRITER;
                    end else begin
                        ph_n = PH_IDLE;
                        fin  = 1'b1;
                    end
                end
            end
            PH_WRITER: begin
                if (ready_i) begin
                    ph_n = PH_IDLE;
                    fin  = 1'b1;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            want_wr_q <= 1'b0;
        end else begin
            ph_q      <= ph_n;
            want_wr_q <= want_wr_n;
        end
    end

    assign phase_o  = ph_q;
    assign finish_o = fin;

    // R8: an accepted reader beat with a writer pending moves to the writer beat.
    a_r8_writer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_READERS && ready_i && want_wr_q) |=> (ph_q == PH_WRITER));

    // R9: an unaccepted beat stays in its phase.
    a_r9_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_IDLE && !ready_i) |=> $stable(ph_q));

    // R8: the writer beat is the last one.
    a_r8_writer_last: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WRITER && ready_i) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/fwd_defer_recorder.sv
// Module: fwd_defer_recorder (top)
// Records forwarded read/write requests during a pending ownership miss and
// replays response descriptors on completion: reader multicast, then writer unicast.
// Assumes: done_i is not raised together with a record strobe.
module fwd_defer_recorder
    import dfr_pkg::*;
#(
    parameter int NODES = 8,
    parameter int ACK_W = 6,
    localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             rd_rec_i,
    input  logic [ID_W-1:0]  rd_id_i,
    input  logic             wr_rec_i,
    input  logic [ID_W-1:0]  wr_id_i,
    input  logic [ACK_W-1:0] wr_acks_i,
    input  logic             done_i,
    input  logic [1:0]       done_mode_i,
    output logic             rsp_valid_o,
    input  logic             rsp_ready_i,
    output logic             rsp_multi_o,
    output logic [NODES-1:0] rsp_dest_set_o,
    output logic [ID_W-1:0]  rsp_dest_id_o,
    output logic [ACK_W-1:0] rsp_acks_o,
    output logic             busy_o,
    output logic             dup_wr_err_o
);
    replay_phase_e    phase;
    logic             finish;
    logic             busy;
    logic             alloc_ok;
    logic             rd_rec_ok;
    logic             wr_rec_ok;
    logic             store_clr;
    logic [NODES-1:0] rd_set;
    logic             wr_held;
    logic [ID_W-1:0]  wr_id;
    logic [ACK_W-1:0] wr_acks;

    // Input gating: strobes count only while no replay is running.
    always_comb begin
        busy      = (phase != PH_IDLE);
        alloc_ok  = alloc_i  && !busy;
        rd_rec_ok = rd_rec_i && !busy;
        wr_rec_ok = wr_rec_i && !busy;
        store_clr = alloc_ok || finish;
    end

    dfr_reader_set #(.NODES(NODES)) u_readers (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (store_clr),
        .rec_i    (rd_rec_ok),
        .rec_id_i (rd_id_i),
        .set_o    (rd_set)
    );

    dfr_writer_slot #(.ID_W(ID_W), .ACK_W(ACK_W)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (store_clr),
        .err_clr_i  (alloc_ok),
        .rec_i      (wr_rec_ok),
        .rec_id_i   (wr_id_i),
        .rec_acks_i (wr_acks_i),
        .held_o     (wr_held),
        .id_o       (wr_id),
        .acks_o     (wr_acks),
        .err_o      (dup_wr_err_o)
    );

    dfr_replay_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .done_i         (done_i),
        .mode_i         (done_mode_i),
        .have_readers_i (|rd_set),
        .have_writer_i  (wr_held),
        .ready_i        (rsp_ready_i),
        .phase_o        (phase),
        .finish_o       (finish)
    );

    // Descriptor mux: fields of the beat in flight, zero otherwise.
    always_comb begin
        rsp_valid_o    = busy;
        rsp_multi_o    = (phase == PH_READERS);
        rsp_dest_set_o = (phase == PH_READERS) ? rd_set  : '0;
        rsp_dest_id_o  = (phase == PH_WRITER)  ? wr_id   : '0;
        rsp_acks_o     = (phase == PH_WRITER)  ? wr_acks : '0;
        busy_o         = busy;
    end

    // R9: a stalled beat keeps valid and every field.
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_multi_o)
            && $stable(rsp_dest_set_o) && $stable(rsp_dest_id_o) && $stable(rsp_acks_o)));

    // R11: storage is frozen while a replay is running.
    a_r11_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> ($stable(rd_set) && $stable(wr_held)));

    // R12: the last accepted beat leaves the storage empty.
    a_r12_empty_after: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && finish) |=> (rd_set == '0 && !wr_held));
endmodule

// File: tb/fwd_defer_recorder_test.sv
module fwd_defer_recorder_test;
    localparam int NODES = 8;
    localparam int ACK_W = 6;
    localparam int ID_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_i = 0, rd_rec_i = 0, wr_rec_i = 0, done_i = 0, rsp_ready_i = 0;
    logic [ID_W-1:0]  rd_id_i = 0, wr_id_i = 0;
    logic [ACK_W-1:0] wr_acks_i = 0;
    logic [1:0]       done_mode_i = 0;
    logic             rsp_valid_o, rsp_multi_o, busy_o, dup_wr_err_o;
    logic [NODES-1:0] rsp_dest_set_o;
    logic [ID_W-1:0]  rsp_dest_id_o;
    logic [ACK_W-1:0] rsp_acks_o;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [NODES-1:0] m_set = '0;
    logic             m_held = 0, m_err = 0;
    logic [ID_W-1:0]  m_id = 0;
    logic [ACK_W-1:0] m_acks = 0;

    fwd_defer_recorder #(.NODES(NODES), .ACK_W(ACK_W)) uut (.*);

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bit_of(int id);
        return 1 << id;
    endfunction

    task automatic do_alloc(bit with_rd, int rid);
        alloc_i = 1; rd_rec_i = with_rd; rd_id_i = rid[ID_W-1:0];
        tick();
        alloc_i = 0; rd_rec_i = 0;
        m_set = '0; m_held = 0; m_err = 0;
        if (with_rd) m_set = m_set | NODES'(bit_of(rid));
    endtask

    task automatic rec_rd(int id);
        rd_rec_i = 1; rd_id_i = id[ID_W-1:0];
        tick();
        rd_rec_i = 0;
        m_set = m_set | NODES'(bit_of(id));
    endtask

    task automatic rec_wr(int id, int acks);
        wr_rec_i = 1; wr_id_i = id[ID_W-1:0]; wr_acks_i = acks[ACK_W-1:0];
        tick();
        wr_rec_i = 0;
        if (m_held) m_err = 1;
        else begin m_held = 1; m_id = id[ID_W-1:0]; m_acks = acks[ACK_W-1:0]; end
        chk("R5", "dup flag", dup_wr_err_o, m_err);
    endtask

    // run a replay and compare every beat with the model
    task automatic replay(int mode, int max_stall, bit poke);
        bit rd_beat = mode[0] && (m_set != 0);
        bit wr_beat = mode[1] && m_held;
        done_i = 1; done_mode_i = mode[1:0];
        tick();
        done_i = 0;
        for (int b = 0; b < 2; b++) begin
            bit is_rd = (b == 0);
            if (is_rd ? !rd_beat : !wr_beat) continue;
            chk("R8", "valid", rsp_valid_o, 1);
            chk("R11", "busy", busy_o, 1);
            chk(is_rd ? "R6" : "R7", "multi", rsp_multi_o, is_rd);
            chk(is_rd ? "R6" : "R7", "set", rsp_dest_set_o, is_rd ? int'(m_set) : 0);
            chk(is_rd ? "R6" : "R7", "id", rsp_dest_id_o, is_rd ? 0 : int'(m_id));
            chk(is_rd ? "R6" : "R7", "acks", rsp_acks_o, is_rd ? 0 : int'(m_acks));
            for (int s = 0; s < (max_stall > 0 ? $urandom % (max_stall + 1) : 0); s++) begin
                if (poke) begin
                    rd_rec_i = 1; rd_id_i = 3'd6; wr_rec_i = 1; wr_id_i = 3'd5;
                    wr_acks_i = 6'd9; done_i = 1; done_mode_i = 2'b11; alloc_i = 1;
                end
                tick();
                rd_rec_i = 0; wr_rec_i = 0; done_i = 0; alloc_i = 0;
                chk("R9", "valid held", rsp_valid_o, 1);
                chk("R9", "multi held", rsp_multi_o, is_rd);
                chk("R9", "set held", rsp_dest_set_o, is_rd ? int'(m_set) : 0);
                chk("R9", "acks held", rsp_acks_o, is_rd ? 0 : int'(m_acks));
                chk("R11", "err untouched", dup_wr_err_o, m_err);
            end
            rsp_ready_i = 1;
            tick();
            rsp_ready_i = 0;
        end
        chk("R10", "valid after", rsp_valid_o, 0);
        chk("R12", "busy after", busy_o, 0);
        m_set = '0; m_held = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run ended)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1", "valid", rsp_valid_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "err", dup_wr_err_o, 0);
        replay(3, 0, 0);  // R1: nothing recorded, no beat
        // R3, R6: accumulate with duplicate
        do_alloc(0, 0);
        rec_rd(2); rec_rd(5); rec_rd(5);
        chk("R3", "set model", m_set, 8'h24);
        replay(1, 0, 0);
        // R4, R7: writer only
        do_alloc(0, 0);
        rec_wr(3, 7);
        replay(2, 2, 0);
        // R5, R8, R9: both, duplicate writer, stalls
        do_alloc(0, 0);
        rec_rd(1); rec_wr(6, 4); rec_wr(2, 9);
        replay(3, 4, 0);
        chk("R5", "err sticky", dup_wr_err_o, 1);
        do_alloc(0, 0);
        chk("R5", "err cleared by alloc", dup_wr_err_o, 0);
        // R10: parts with nothing recorded skipped
        rec_wr(4, 12);
        replay(3, 0, 0);
        do_alloc(0, 0);
        rec_rd(0);
        replay(2, 0, 0);
        replay(3, 0, 0);  // R12: reader dropped by previous completion
        // R2: alloc with same-cycle record
        do_alloc(0, 0);
        rec_rd(4); rec_wr(1, 3);
        do_alloc(1, 7);
        replay(3, 0, 0);
        // R11: strobes during replay ignored
        do_alloc(0, 0);
        rec_rd(0);
        replay(1, 3, 1);
        replay(3, 0, 0);
        chk("R11", "err after pokes", dup_wr_err_o, 0);
        // R12: unreplayed writer freed
        do_alloc(0, 0);
        rec_rd(1); rec_wr(2, 5);
        replay(1, 0, 0);
        replay(2, 0, 0);
        // random mix
        for (int it = 0; it < 60; it++) begin
            if ($urandom % 3 != 0) do_alloc(0, 0);
            for (int k = 0; k < int'($urandom % 6); k++) begin
                if ($urandom % 2) rec_rd($urandom % NODES);
                else rec_wr($urandom % NODES, $urandom % 64);
            end
            replay($urandom % 4, 3, ($urandom % 4) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule